// File: doc/BRIEF.md
# State Occupancy Profiling Counter Bank

This block watches the encoded state register of a finite state machine elsewhere in a design and counts, for every state code, how many clock cycles the machine spent in that state. Next to the per-state counters it keeps a cycle counter that advances on every cycle that is counted. The cycle counter therefore gives the denominator for occupancy ratios. Each counter has a sticky wrap flag, so a host can tell a small count from one that has rolled over.

Counting starts after reset. It can be halted with a stop pulse and restarted with a run pulse. A clear pulse zeroes every count and every flag. A host reads any count through a request/index port, and the answer returns on the next cycle with a valid strobe. The counter width is a parameter, 32 bits by default. The bench narrows it so that a wrap can be reached in a short run.

Top module: `state_occupancy_profiler`

## Requirements
- R1: After reset, every state counter, the cycle counter and all wrap flags are zero, `rd_valid_o` is low, and the block is counting.
- R2: On each counting cycle, exactly one state counter advances by one: the one whose index equals `state_i` (4 bits, codes 0 to 15). No other state counter changes.
- R3: The cycle counter advances by one on every counting cycle and holds on every other cycle.
- R4: Wrap flags are sticky, and only a clear resets them. Flag bit k (k = 0..15) is set when state counter k steps from all ones to zero. Bit 16 is set when the cycle counter does so. Bits above 16 read as zero.
- R5: A cycle with `clear_i` high zeroes all counters and flags at that clock edge, and nothing is counted in that cycle. Clear does not change whether the block is running.
- R6: A cycle with `stop_i` high counts nothing, and counting stays halted until `run_i` is seen. Counting resumes in the same cycle in which `run_i` is high. If `stop_i` and `run_i` are high together, stop wins.
- R7: If `clear_i` and `stop_i` are high in the same cycle, the block ends up with every counter at zero and halted.
- R8: A read request with index `rd_idx_i` produces `rd_valid_o` high for exactly one cycle on the next cycle. The data is the value held just before the request's clock edge. Index 0..15 selects state counters, 16 selects the cycle counter, 17 selects the flags, and 18..31 return zero.
- R9: Counters are modular. After wrapping, a counter continues upward from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | 4 | Encoded state of the monitored machine |
| run_i | input | 1 | Start or resume counting |
| stop_i | input | 1 | Halt counting |
| clear_i | input | 1 | Zero all counters and flags |
| rd_req_i | input | 1 | Read request strobe |
| rd_idx_i | input | 5 | Read index |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | max(CNT_W,17) | Read data |

## Verification
Every result of this block is due at the first clock edge after its stimulus. A count, a clear, a stop or a wrap flag appears in the registered state at the edge that samples the control. A read answer appears at `rd_valid_o` one edge after its request, and it shows the state from before that edge. The bench keeps a behavioural model that it updates at each rising edge, in the same order as these rules. The bench compares the read port against that model on the falling edge that follows, so every sample lands exactly one register stage after its cause. The bench issues reads on almost every cycle, so stop, clear and wrap effects are observed in the very next read.

// File: rtl/profile_pkg.sv
package profile_pkg;
  typedef enum logic [1:0] {
    SEL_STATE = 2'd0,
    SEL_CYCLE = 2'd1,
    SEL_FLAGS = 2'd2,
    SEL_NONE  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/occ_run_ctrl.sv
module occ_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic stop_i,
  input  logic clear_i,
  output logic run_q_o,
  output logic count_en_o
);
  logic run_q;
  logic run_nxt;
  logic live;

  // Stop outranks run; a run pulse counts in its own cycle (R6)
  always_comb begin
    live       = (run_q | run_i) & ~stop_i;
    run_nxt    = live;
    count_en_o = live & ~clear_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= run_nxt;
  end

  assign run_q_o = run_q;
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = clr_i | inc_i;
    cnt_nxt = clr_i ? '0 : cnt_q + W'(1);
    wrap_o  = inc_i & ~clr_i & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/occ_readout.sv
module occ_readout
  import profile_pkg::*;
#(
  parameter int NS    = 16,
  parameter int W     = 32,
  parameter int NF    = 17,
  parameter int RD_W  = 32,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [NS-1:0][W-1:0]   cnt_i,
  input  logic [W-1:0]           cyc_i,
  input  logic [NF-1:0]          flags_i,
  output logic                   valid_o,
  output logic [RD_W-1:0]        data_o
);
  localparam int SW = $clog2(NS);

  rd_sel_e        sel;
  logic [RD_W-1:0] data_nxt;
  logic [RD_W-1:0] data_q;
  logic            valid_q;

  always_comb begin
    if (idx_i < IDX_W'(NS))          sel = SEL_STATE;
    else if (idx_i == IDX_W'(NS))    sel = SEL_CYCLE;
    else if (idx_i == IDX_W'(NS+1))  sel = SEL_FLAGS;
    else                             sel = SEL_NONE;
    case (sel)
      SEL_STATE: data_nxt = RD_W'(cnt_i[idx_i[SW-1:0]]);
      SEL_CYCLE: data_nxt = RD_W'(cyc_i);
      SEL_FLAGS: data_nxt = RD_W'(flags_i);
      default:   data_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (req_i) data_q <= data_nxt;
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/state_occupancy_profiler.sv
module state_occupancy_profiler #(
  parameter int NUM_STATES = 16,
  parameter int CNT_W      = 32,
  localparam int STATE_W   = $clog2(NUM_STATES),
  localparam int IDX_W     = $clog2(NUM_STATES + 2),
  localparam int NUM_FLAGS = NUM_STATES + 1,
  localparam int RD_W      = (CNT_W > NUM_FLAGS) ? CNT_W : NUM_FLAGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               run_i,
  input  logic               stop_i,
  input  logic               clear_i,
  input  logic               rd_req_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [RD_W-1:0]    rd_data_o
);
  logic                             run_q;
  logic                             count_en;
  logic [NUM_STATES-1:0]            st_hit;
  logic [NUM_STATES-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_FLAGS-1:0]             wrap;
  logic [CNT_W-1:0]                 cyc_cnt_q;
  logic [NUM_FLAGS-1:0]             ovf_q;
  logic [NUM_FLAGS-1:0]             ovf_nxt;
  logic                             ovf_en;

  occ_run_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .stop_i     (stop_i),
    .clear_i    (clear_i),
    .run_q_o    (run_q),
    .count_en_o (count_en)
  );

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    assign st_hit[s] = count_en & (state_i == STATE_W'(s));
    occ_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clear_i),
      .inc_i  (st_hit[s]),
      .cnt_o  (cnt_q[s]),
      .wrap_o (wrap[s])
    );
  end

  occ_counter #(.W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clear_i),
    .inc_i  (count_en),
    .cnt_o  (cyc_cnt_q),
    .wrap_o (wrap[NUM_STATES])
  );

  always_comb begin
    ovf_en  = clear_i | (|wrap);
    ovf_nxt = clear_i ? '0 : (ovf_q | wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= '0;
    else if (ovf_en) ovf_q <= ovf_nxt;
  end

  occ_readout #(
    .NS    (NUM_STATES),
    .W     (CNT_W),
    .NF    (NUM_FLAGS),
    .RD_W  (RD_W),
    .IDX_W (IDX_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (rd_req_i),
    .idx_i   (rd_idx_i),
    .cnt_i   (cnt_q),
    .cyc_i   (cyc_cnt_q),
    .flags_i (ovf_q),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/occ_prof_checker.sv
module occ_prof_checker #(
  parameter int CNT_W = 32,
  parameter int NF    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic             stop_i,
  input logic             clear_i,
  input logic             rd_req_i,
  input logic             rd_valid_o,
  input logic             run_q,
  input logic [CNT_W-1:0] cyc_cnt_q,
  input logic [NF-1:0]    ovf_q
);
  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o);

  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_valid_o);

  assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_q || run_i) && !stop_i && !clear_i) |=> cyc_cnt_q == CNT_W'($past(cyc_cnt_q) + 1'b1));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cyc_cnt_q == '0) && (ovf_q == '0));

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !clear_i) |=> $stable(cyc_cnt_q));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  assert_clear_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && stop_i) |=> (!run_q && cyc_cnt_q == '0));
endmodule

bind state_occupancy_profiler occ_prof_checker #(
  .CNT_W (CNT_W),
  .NF    (NUM_STATES + 1)
) u_occ_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .stop_i     (stop_i),
  .clear_i    (clear_i),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .run_q      (run_q),
  .cyc_cnt_q  (cyc_cnt_q),
  .ovf_q      (ovf_q)
);

// File: tb/state_occupancy_profiler_bench.sv
`timescale 1ns/1ps
module state_occupancy_profiler_bench;
  localparam int CW   = 12;
  localparam int RDW  = 17;
  localparam int MASK = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  state_i = '0;
  logic        run_i = 1'b0, stop_i = 1'b0, clear_i = 1'b0, rd_req_i = 1'b0;
  logic [4:0]  rd_idx_i = '0;
  logic        rd_valid_o;
  logic [RDW-1:0] rd_data_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_cnt [16];
  int m_cyc, m_flags, m_data;
  bit m_run, m_vld;

  always #2.5 clk = ~clk;

  state_occupancy_profiler #(.NUM_STATES(16), .CNT_W(CW)) u_state_occupancy_profiler (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .run_i(run_i), .stop_i(stop_i),
    .clear_i(clear_i), .rd_req_i(rd_req_i), .rd_idx_i(rd_idx_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o));

  // Behavioural reference: answer read from old state, then apply the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_cyc = 0; m_flags = 0; m_run = 1; m_vld = 0; m_data = 0;
    end else begin
      bit en;
      m_vld = rd_req_i;
      if (rd_req_i) begin
        if (rd_idx_i < 16)       m_data = m_cnt[rd_idx_i];
        else if (rd_idx_i == 16) m_data = m_cyc;
        else if (rd_idx_i == 17) m_data = m_flags;
        else                     m_data = 0;
      end
      en = (m_run || run_i) && !stop_i && !clear_i;
      if (clear_i) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_cyc = 0; m_flags = 0;
      end else if (en) begin
        if (m_cnt[state_i] == MASK) m_flags = m_flags | (1 << state_i);
        m_cnt[state_i] = (m_cnt[state_i] + 1) & MASK;
        if (m_cyc == MASK) m_flags = m_flags | (1 << 16);
        m_cyc = (m_cyc + 1) & MASK;
      end
      m_run = (m_run || run_i) && !stop_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (rd_valid_o !== m_vld) begin
        mismatched++;
        $display("FAIL %s (R8 strobe): rd_valid actual %0b expected %0b", cur_req, rd_valid_o, m_vld);
      end else if (m_vld) begin
        compared++;
        if (rd_data_o !== RDW'(m_data)) begin
          mismatched++;
          $display("FAIL %s: rd_data actual %0d expected %0d", cur_req, rd_data_o, m_data);
        end
      end
    end
  end

  task automatic step(input logic [3:0] st, input bit run, input bit stop,
                      input bit clr, input bit req, input logic [4:0] idx);
    @(negedge clk);
    state_i = st; run_i = run; stop_i = stop; clear_i = clr;
    rd_req_i = req; rd_idx_i = idx;
  endtask

  task automatic read_all();
    for (int i = 0; i < 20; i++) step(4'(i), 0, 0, 0, 1, 5'(i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: no read strobe straight after reset
    @(posedge clk); #1;
    compared++;
    if (rd_valid_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: rd_valid actual %0b expected 0", rd_valid_o);
    end
    cur_req = "R1";
    step(4'd0, 0, 1, 0, 1, 5'd16);
    for (int i = 0; i < 18; i++) step(4'd0, 0, 0, 0, 1, 5'(i));
    step(4'd0, 1, 0, 0, 0, 5'd0);
    // R2/R3: walking and random states, reads on all indices (R8 covers 18..31)
    cur_req = "R2";
    for (int i = 0; i < 64; i++) step(4'(i), 0, 0, 0, 1, 5'(i % 18));
    for (int i = 0; i < 400; i++) step(4'($urandom_range(0, 15)), 0, 0, 0, 1, 5'($urandom_range(0, 31)));
    cur_req = "R3";
    for (int i = 0; i < 40; i++) step(4'(i % 3), 0, 0, 0, 1, 5'd16);
    read_all();
    // R6: stop halts, run+stop stays halted, run resumes in its cycle
    cur_req = "R6";
    step(4'd5, 0, 1, 0, 1, 5'd5);
    for (int i = 0; i < 30; i++) step(4'(i), 0, 0, 0, 1, 5'(i % 18));
    step(4'd5, 1, 1, 0, 1, 5'd16);
    step(4'd5, 0, 0, 0, 1, 5'd16);
    step(4'd5, 1, 0, 0, 1, 5'd5);
    step(4'd5, 0, 0, 0, 1, 5'd5);
    step(4'd5, 0, 0, 0, 1, 5'd16);
    read_all();
    // R5: clear while running keeps running
    cur_req = "R5";
    step(4'd7, 0, 0, 1, 1, 5'd7);
    read_all();
    step(4'd7, 0, 0, 1, 0, 5'd0);
    step(4'd7, 0, 0, 0, 1, 5'd7);
    step(4'd7, 0, 0, 0, 1, 5'd16);
    // R7: clear with stop
    cur_req = "R7";
    step(4'd2, 0, 1, 1, 1, 5'd16);
    for (int i = 0; i < 20; i++) step(4'(i), 0, 0, 0, 1, 5'(i % 18));
    step(4'd3, 1, 0, 0, 1, 5'd17);
    // R4/R9: drive state 3 past a wrap of its counter and of the cycle counter
    cur_req = "R4";
    for (int i = 0; i < MASK + 40; i++) step(4'd3, 0, 0, 0, 1, 5'(i % 18));
    cur_req = "R9";
    for (int i = 0; i < 30; i++) step(4'(i % 2 + 3), 0, 0, 0, 1, (i % 2) ? 5'd3 : 5'd17);
    read_all();
    cur_req = "R4";
    step(4'd3, 0, 1, 0, 1, 5'd17);
    for (int i = 0; i < 10; i++) step(4'd3, 0, 0, 0, 1, 5'd17);
    step(4'd3, 0, 0, 1, 1, 5'd17);
    step(4'd3, 0, 0, 0, 1, 5'd17);
    step(4'd3, 0, 0, 0, 0, 5'd0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule